// File: doc/BRIEF.md
# ATA Task-File Register Decoder

This block is the device-side register front end of a parallel ATA drive running in the classic IDE register mode. Each clock it looks at the two active-low chip selects, the three address lines, the DMA acknowledge and the active-low read and write strobes. From them it picks one target: the data port, one of the task-file registers, or the control/alternate-status register. Writes update register storage. Reads put the selected value on a 16-bit host data output and raise an output enable.

Data-port traffic goes to a buffer-side FIFO through a one-word pop/push handshake. In byte mode a PIO data access carries one byte, and two accesses move one word. Error and status bits come from the drive core. The block gives the core the latched task-file values, a command opcode with a one-cycle valid pulse, the current transfer mode, the soft-reset level and the masked interrupt request.

Top module: `ata_taskfile`

## Requirements
- R1: With CS1 high, CS0 low and DMACK high, address 0 selects the data port. Address 1 selects error on read and features on write. Addresses 2 to 6 select sector count, sector number, cylinder low, cylinder high and drive/head. Address 7 selects status on read and command on write. Register reads return the value on hd_o[7:0] with hd_o[15:8] zero.
- R2: With CS1 low, CS0 high, DMACK high and address 6, a read returns the status byte and a write loads the control register. In the control register, bit 2 is soft reset and bit 1 masks the interrupt.
- R3: With DMACK low and both chip selects high, the access is a 16-bit data-port transfer. This holds for any address value and in byte mode.
- R4: A PIO access at address 1 with wide_i high goes to the data port. The features register does not change.
- R5: A command write of 0xEF enables byte mode when the features register holds 0x01, and disables it when it holds 0x81. In byte mode a PIO data read returns the low byte of the FIFO head first and then the high byte, and pops on the second read. PIO data writes are assembled low byte first, and one word is pushed on the second write.
- R6: In word mode each PIO data read returns the FIFO head and pops it in the same cycle. Each PIO data write pushes hd_i in the same cycle.
- R7: A read of the error register returns core_err_i, for example bit 7 bad block and bit 6 uncorrectable. A write at that offset loads the features register only.
- R8: core_irq_i sets a pending interrupt. A status read (CS0 block, address 7) clears it. An alternate-status read leaves it pending. intrq_o is the pending bit gated by the mask bit.
- R9: An accepted command write puts the opcode on cmd_o and raises cmd_valid_o for exactly one cycle after the write. It also sets BSY (status bit 7), which core_done_i clears.
- R10: While BSY is set, writes to the features, task-file and command registers have no effect.
- R11: A control write with bit 2 set restores the task-file defaults: sector count 1, sector number 1, all others 0. It also clears byte mode and the pending interrupt and sets BSY. BSY stays set while the bit stays set, and after it clears BSY holds until core_done_i.
- R12: After reset, the task file holds its defaults, BSY is 0, byte mode is off, no interrupt is pending and cmd_valid_o is 0.
- R13: A cycle with both chip selects low, or with DMACK low together with a chip select low, or with CS1 low at an address other than 6, selects nothing. It raises no output enable, no pop and no push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs0_ni | input | 1 | Command-block chip select, active low |
| cs1_ni | input | 1 | Control-block chip select, active low |
| addr_i | input | 3 | Register address |
| dmack_ni | input | 1 | DMA acknowledge, active low |
| iord_ni | input | 1 | Read strobe, active low |
| iowr_ni | input | 1 | Write strobe, active low |
| wide_i | input | 1 | Host access is 16 bits wide |
| hd_i | input | 16 | Host write data |
| hd_o | output | 16 | Host read data |
| hd_oe_o | output | 1 | Read data valid / bus drive enable |
| fifo_rdata_i | input | 16 | FIFO head word |
| fifo_pop_o | output | 1 | Pop one word |
| fifo_wdata_o | output | 16 | Word to push |
| fifo_push_o | output | 1 | Push one word |
| core_err_i | input | 8 | Error register contents from core |
| core_stat_i | input | 7 | Status bits 6..0 from core |
| core_done_i | input | 1 | Core releases BSY |
| core_irq_i | input | 1 | Core raises an interrupt |
| cmd_o | output | 8 | Latched command opcode |
| cmd_valid_o | output | 1 | One-cycle new-command pulse |
| tf_feat_o | output | 8 | Features register |
| tf_scnt_o | output | 8 | Sector count |
| tf_snum_o | output | 8 | Sector number |
| tf_cyl_o | output | 16 | Cylinder high and low |
| tf_head_o | output | 8 | Drive/head register |
| byte_mode_o | output | 1 | PIO data port in byte mode |
| srst_o | output | 1 | Soft-reset bit of control register |
| intrq_o | output | 1 | Interrupt request to host |

## Verification
The assertions assume that each host access is a single-cycle strobe and that read and write strobes are never low together. They also assume the core does not signal done in the same cycle that a command is accepted. The bench keeps to this: each access occupies exactly one cycle between idle-driven steps, and core_done_i and core_irq_i are pulsed only in cycles with no host strobe. Illegal selects are driven only as reads, so that R13 is checked by the output enable and the FIFO strobes staying low.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int ADDR_W = 3;
  localparam int REG_W  = 8;
  localparam logic [REG_W-1:0] OP_SET_FEAT   = 8'hEF;
  localparam logic [REG_W-1:0] FEAT_BYTE_ON  = 8'h01;
  localparam logic [REG_W-1:0] FEAT_BYTE_OFF = 8'h81;
  localparam int CTL_SRST = 2;
  localparam int CTL_NIEN = 1;

  typedef enum logic [3:0] {
    TGT_NONE, TGT_PIO, TGT_DMA, TGT_ERRFEAT, TGT_SCNT, TGT_SNUM,
    TGT_CYLL, TGT_CYLH, TGT_HEAD, TGT_STATCMD, TGT_ALTCTL
  } tgt_e;

  typedef struct packed {
    logic [REG_W-1:0] feat;
    logic [REG_W-1:0] scnt;
    logic [REG_W-1:0] snum;
    logic [REG_W-1:0] cyll;
    logic [REG_W-1:0] cylh;
    logic [REG_W-1:0] head;
  } tf_t;

  localparam tf_t TF_DEFAULT = '{feat: 8'h00, scnt: 8'h01, snum: 8'h01,
                                 cyll: 8'h00, cylh: 8'h00, head: 8'h00};
endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
  import ata_tf_pkg::*;
(
  input  logic              cs0_ni,
  input  logic              cs1_ni,
  input  logic              dmack_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  output tgt_e              tgt_o
);
  always_comb begin
    tgt_o = TGT_NONE;
    if (!dmack_ni) begin
      if (cs0_ni && cs1_ni) tgt_o = TGT_DMA;
    end else if (!cs0_ni && cs1_ni) begin
      case (addr_i)
        3'd0: tgt_o = TGT_PIO;
        3'd1: tgt_o = wide_i ? TGT_PIO : TGT_ERRFEAT; // overlap: word goes to data
        3'd2: tgt_o = TGT_SCNT;
        3'd3: tgt_o = TGT_SNUM;
        3'd4: tgt_o = TGT_CYLL;
        3'd5: tgt_o = TGT_CYLH;
        3'd6: tgt_o = TGT_HEAD;
        default: tgt_o = TGT_STATCMD;
      endcase
    end else if (cs0_ni && !cs1_ni && addr_i == 3'd6) begin
      tgt_o = TGT_ALTCTL;
    end
  end
endmodule

// File: rtl/ata_tf_dport.sv
module ata_tf_dport #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          narrow_i,
  input  logic          clr_i,
  input  logic [DW-1:0] hd_i,
  input  logic [DW-1:0] fifo_rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          pop_o,
  output logic          push_o,
  output logic [DW-1:0] wdata_o
);
  localparam int BW = DW / 2;

  logic          tgl_q;
  logic [BW-1:0] lo_q;

  always_comb begin
    pop_o  = rd_i & (~narrow_i | tgl_q);
    push_o = wr_i & (~narrow_i | tgl_q);
    if (narrow_i) begin
      rdata_o = {{BW{1'b0}}, tgl_q ? fifo_rdata_i[DW-1:BW] : fifo_rdata_i[BW-1:0]};
      wdata_o = {hd_i[BW-1:0], lo_q};
    end else begin
      rdata_o = fifo_rdata_i;
      wdata_o = hd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q <= 1'b0;
      lo_q  <= '0;
    end else begin
      if (clr_i) tgl_q <= 1'b0;
      else if ((rd_i | wr_i) & narrow_i) tgl_q <= ~tgl_q;
      if (wr_i & narrow_i & ~tgl_q) lo_q <= hd_i[BW-1:0];
    end
  end
endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tgt_e             tgt_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] core_err_i,
  input  logic [REG_W-2:0] core_stat_i,
  input  logic             core_done_i,
  input  logic             core_irq_i,
  output logic [REG_W-1:0] rdata_o,
  output tf_t              tf_o,
  output logic [REG_W-1:0] cmd_o,
  output logic             cmd_valid_o,
  output logic             byte_mode_o,
  output logic             srst_o,
  output logic             nien_o,
  output logic             bsy_o,
  output logic             intrq_o,
  output logic             tgl_clr_o,
  output logic             srst_wr_o
);
  tf_t              tf_q;
  logic [REG_W-1:0] cmd_q;
  logic             cmd_v_q, byte_q, srst_q, nien_q, bsy_q, irq_q;
  logic             ctl_wr, srst_wr, tf_wr, cmd_acc, setfeat, stat_rd;
  logic [REG_W-1:0] status;

  assign ctl_wr  = wr_i && tgt_i == TGT_ALTCTL;
  assign srst_wr = ctl_wr && wdata_i[CTL_SRST];
  assign tf_wr   = wr_i && !bsy_q;
  assign cmd_acc = tf_wr && tgt_i == TGT_STATCMD;
  assign setfeat = cmd_acc && wdata_i == OP_SET_FEAT;
  assign stat_rd = rd_i && tgt_i == TGT_STATCMD;
  assign status  = {bsy_q, core_stat_i};

  always_comb begin
    case (tgt_i)
      TGT_ERRFEAT:             rdata_o = core_err_i;
      TGT_SCNT:                rdata_o = tf_q.scnt;
      TGT_SNUM:                rdata_o = tf_q.snum;
      TGT_CYLL:                rdata_o = tf_q.cyll;
      TGT_CYLH:                rdata_o = tf_q.cylh;
      TGT_HEAD:                rdata_o = tf_q.head;
      TGT_STATCMD, TGT_ALTCTL: rdata_o = status;
      default:                 rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tf_q    <= TF_DEFAULT;
      cmd_q   <= '0;
      cmd_v_q <= 1'b0;
      byte_q  <= 1'b0;
      srst_q  <= 1'b0;
      nien_q  <= 1'b0;
      bsy_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cmd_v_q <= cmd_acc;
      if (cmd_acc) cmd_q <= wdata_i;

      if (srst_wr) tf_q <= TF_DEFAULT;
      else if (tf_wr) begin
        case (tgt_i)
          TGT_ERRFEAT: tf_q.feat <= wdata_i;
          TGT_SCNT:    tf_q.scnt <= wdata_i;
          TGT_SNUM:    tf_q.snum <= wdata_i;
          TGT_CYLL:    tf_q.cyll <= wdata_i;
          TGT_CYLH:    tf_q.cylh <= wdata_i;
          TGT_HEAD:    tf_q.head <= wdata_i;
          default: ;
        endcase
      end

      if (ctl_wr) begin
        srst_q <= wdata_i[CTL_SRST];
        nien_q <= wdata_i[CTL_NIEN];
      end

      if (srst_wr) byte_q <= 1'b0;
      else if (setfeat && tf_q.feat == FEAT_BYTE_ON) byte_q <= 1'b1;
      else if (setfeat && tf_q.feat == FEAT_BYTE_OFF) byte_q <= 1'b0;

      if (srst_wr || srst_q) bsy_q <= 1'b1;
      else if (cmd_acc) bsy_q <= 1'b1;
      else if (core_done_i) bsy_q <= 1'b0;

      if (srst_wr) irq_q <= 1'b0;
      else if (core_irq_i) irq_q <= 1'b1;
      else if (stat_rd) irq_q <= 1'b0;
    end
  end

  assign tf_o        = tf_q;
  assign cmd_o       = cmd_q;
  assign cmd_valid_o = cmd_v_q;
  assign byte_mode_o = byte_q;
  assign srst_o      = srst_q;
  assign nien_o      = nien_q;
  assign bsy_o       = bsy_q;
  assign intrq_o     = irq_q & ~nien_q;
  assign tgl_clr_o   = srst_wr | setfeat;
  assign srst_wr_o   = srst_wr;
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs0_ni,
  input  logic              cs1_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dmack_ni,
  input  logic              iord_ni,
  input  logic              iowr_ni,
  input  logic              wide_i,
  input  logic [DW-1:0]     hd_i,
  output logic [DW-1:0]     hd_o,
  output logic              hd_oe_o,
  input  logic [DW-1:0]     fifo_rdata_i,
  output logic              fifo_pop_o,
  output logic [DW-1:0]     fifo_wdata_o,
  output logic              fifo_push_o,
  input  logic [REG_W-1:0]  core_err_i,
  input  logic [REG_W-2:0]  core_stat_i,
  input  logic              core_done_i,
  input  logic              core_irq_i,
  output logic [REG_W-1:0]  cmd_o,
  output logic              cmd_valid_o,
  output logic [REG_W-1:0]  tf_feat_o,
  output logic [REG_W-1:0]  tf_scnt_o,
  output logic [REG_W-1:0]  tf_snum_o,
  output logic [2*REG_W-1:0] tf_cyl_o,
  output logic [REG_W-1:0]  tf_head_o,
  output logic              byte_mode_o,
  output logic              srst_o,
  output logic              intrq_o
);
  tgt_e             tgt;
  logic             rd, wr, is_dp, narrow, tgl_clr, bsy, nien, srst_wr;
  logic [DW-1:0]    dp_rdata;
  logic [REG_W-1:0] reg_rdata;
  tf_t              tf;

  assign rd     = ~iord_ni & iowr_ni;
  assign wr     = ~iowr_ni & iord_ni;
  assign is_dp  = (tgt == TGT_PIO) || (tgt == TGT_DMA);
  assign narrow = byte_mode_o && tgt == TGT_PIO;

  ata_tf_decode i_dec (
    .cs0_ni  (cs0_ni),
    .cs1_ni  (cs1_ni),
    .dmack_ni(dmack_ni),
    .addr_i  (addr_i),
    .wide_i  (wide_i),
    .tgt_o   (tgt)
  );

  ata_tf_dport #(.DW(DW)) i_dport (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd & is_dp),
    .wr_i        (wr & is_dp),
    .narrow_i    (narrow),
    .clr_i       (tgl_clr),
    .hd_i        (hd_i),
    .fifo_rdata_i(fifo_rdata_i),
    .rdata_o     (dp_rdata),
    .pop_o       (fifo_pop_o),
    .push_o      (fifo_push_o),
    .wdata_o     (fifo_wdata_o)
  );

  ata_tf_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tgt_i      (tgt),
    .rd_i       (rd),
    .wr_i       (wr),
    .wdata_i    (hd_i[REG_W-1:0]),
    .core_err_i (core_err_i),
    .core_stat_i(core_stat_i),
    .core_done_i(core_done_i),
    .core_irq_i (core_irq_i),
    .rdata_o    (reg_rdata),
    .tf_o       (tf),
    .cmd_o      (cmd_o),
    .cmd_valid_o(cmd_valid_o),
    .byte_mode_o(byte_mode_o),
    .srst_o     (srst_o),
    .nien_o     (nien),
    .bsy_o      (bsy),
    .intrq_o    (intrq_o),
    .tgl_clr_o  (tgl_clr),
    .srst_wr_o  (srst_wr)
  );

  assign hd_o      = is_dp ? dp_rdata : {{(DW-REG_W){1'b0}}, reg_rdata};
  assign hd_oe_o   = rd && tgt != TGT_NONE;
  assign tf_feat_o = tf.feat;
  assign tf_scnt_o = tf.scnt;
  assign tf_snum_o = tf.snum;
  assign tf_cyl_o  = {tf.cylh, tf.cyll};
  assign tf_head_o = tf.head;
endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        iord_ni,
  input logic        iowr_ni,
  input logic        hd_oe_o,
  input logic        fifo_pop_o,
  input logic        fifo_push_o,
  input logic        cmd_valid_o,
  input logic        srst_o,
  input logic        intrq_o,
  input logic        bsy,
  input logic        nien,
  input logic        srst_wr,
  input logic [55:0] tf_all
);
  a_r9_cmd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  a_r9_cmd_sets_bsy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> bsy);
  a_r10_busy_tf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bsy && !srst_wr) |=> $stable(tf_all));
  a_r11_srst_bsy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |-> bsy);
  a_r8_intrq_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intrq_o |-> !nien);
  a_r6_pop_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (hd_oe_o && !iord_ni));
  a_r13_push_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |-> !iowr_ni);
  a_r5_pop_push_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_pop_o && fifo_push_o));
endmodule

bind ata_taskfile ata_taskfile_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .iord_ni    (iord_ni),
  .iowr_ni    (iowr_ni),
  .hd_oe_o    (hd_oe_o),
  .fifo_pop_o (fifo_pop_o),
  .fifo_push_o(fifo_push_o),
  .cmd_valid_o(cmd_valid_o),
  .srst_o     (srst_o),
  .intrq_o    (intrq_o),
  .bsy        (bsy),
  .nien       (nien),
  .srst_wr    (srst_wr),
  .tf_all     ({tf_feat_o, tf_scnt_o, tf_snum_o, tf_cyl_o, tf_head_o})
);

// File: tb/test_ata_taskfile.sv
module test_ata_taskfile;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cs0_ni = 1, cs1_ni = 1, dmack_ni = 1, iord_ni = 1, iowr_ni = 1, wide_i = 0;
  logic [2:0]  addr_i = 0;
  logic [15:0] hd_i = 0, fifo_rdata_i = 0;
  logic [7:0]  core_err_i = 8'hC0;
  logic [6:0]  core_stat_i = 7'h50;
  logic        core_done_i = 0, core_irq_i = 0;
  logic [15:0] hd_o, fifo_wdata_o, tf_cyl_o;
  logic        hd_oe_o, fifo_pop_o, fifo_push_o, cmd_valid_o, byte_mode_o, srst_o, intrq_o;
  logic [7:0]  cmd_o, tf_feat_o, tf_scnt_o, tf_snum_o, tf_head_o;

  ata_taskfile i_ata_taskfile (.*);

  always #2.5ns clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  string cur_req = "R12";
  logic [15:0] rq[$];

  // behavioural model state
  logic [7:0] m_feat = 0, m_scnt = 1, m_snum = 1, m_cyll = 0, m_cylh = 0, m_head = 0;
  logic [7:0] m_cmd = 0, m_lo = 0;
  bit m_cmdv = 0, m_bsy = 0, m_irq = 0, m_nien = 0, m_srst = 0, m_byte = 0, m_tgl = 0;

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // kinds: 0 idle 1 pio rd 2 pio wr 3 cs1 rd 4 cs1 wr 5 dma rd 6 dma wr 7 both-cs rd 8 dmack+cs0 rd
  function automatic int target(int kind, logic [2:0] a, logic w);
    if (kind == 1 || kind == 2) begin
      if (a == 0) return 1;
      if (a == 1) return w ? 1 : 3;
      return int'(a) + 2;
    end
    if (kind == 3 || kind == 4) return (a == 6) ? 10 : 0;
    if (kind == 5 || kind == 6) return 2;
    return 0;
  endfunction

  task automatic step(int kind, logic [2:0] a = 0, logic [15:0] d = 0, logic w = 0,
                      logic done = 0, logic irq = 0);
    int t;
    bit rd, wr, dp, nar, srstw, cmdacc, old_srst, old_bsy;
    logic [15:0] er;
    cs0_ni   = !(kind == 1 || kind == 2 || kind == 7 || kind == 8);
    cs1_ni   = !(kind == 3 || kind == 4 || kind == 7);
    dmack_ni = !(kind == 5 || kind == 6 || kind == 8);
    iord_ni  = !(kind == 1 || kind == 3 || kind == 5 || kind == 7 || kind == 8);
    iowr_ni  = !(kind == 2 || kind == 4 || kind == 6);
    addr_i = a; hd_i = d; wide_i = w; core_done_i = done; core_irq_i = irq;
    t   = target(kind, a, w);
    rd  = !iord_ni && t != 0;
    wr  = !iowr_ni && t != 0;
    dp  = (t == 1 || t == 2);
    nar = m_byte && t == 1;
    #1ns;
    chk("hd_oe_o", hd_oe_o, rd);
    if (rd) begin
      if (dp) er = nar ? (m_tgl ? {8'h0, fifo_rdata_i[15:8]} : {8'h0, fifo_rdata_i[7:0]}) : fifo_rdata_i;
      else case (t)
        3: er = {8'h0, core_err_i};
        4: er = {8'h0, m_scnt};
        5: er = {8'h0, m_snum};
        6: er = {8'h0, m_cyll};
        7: er = {8'h0, m_cylh};
        8: er = {8'h0, m_head};
        default: er = {8'h0, m_bsy, core_stat_i};
      endcase
      chk("hd_o", hd_o, er);
    end
    chk("fifo_pop_o", fifo_pop_o, rd && dp && (!nar || m_tgl));
    chk("fifo_push_o", fifo_push_o, wr && dp && (!nar || m_tgl));
    if (wr && dp && (!nar || m_tgl)) chk("fifo_wdata_o", fifo_wdata_o, nar ? {d[7:0], m_lo} : d);
    chk("cmd_valid_o", cmd_valid_o, m_cmdv);
    chk("cmd_o", cmd_o, m_cmd);
    chk("tf_feat_o", tf_feat_o, m_feat);
    chk("tf_scnt_o", tf_scnt_o, m_scnt);
    chk("tf_snum_o", tf_snum_o, m_snum);
    chk("tf_cyl_o", tf_cyl_o, {m_cylh, m_cyll});
    chk("tf_head_o", tf_head_o, m_head);
    chk("byte_mode_o", byte_mode_o, m_byte);
    chk("srst_o", srst_o, m_srst);
    chk("intrq_o", intrq_o, m_irq && !m_nien);
    @(posedge clk_i);
    old_srst = m_srst; old_bsy = m_bsy;
    srstw  = wr && t == 10 && d[2];
    cmdacc = wr && !old_bsy && t == 9;
    m_cmdv = cmdacc;
    if (cmdacc) m_cmd = d[7:0];
    if (dp && nar) begin
      if (wr && !m_tgl) m_lo = d[7:0];
      m_tgl = !m_tgl;
    end
    if (cmdacc && d[7:0] == 8'hEF) begin
      if (m_feat == 8'h01) m_byte = 1;
      else if (m_feat == 8'h81) m_byte = 0;
      m_tgl = 0;
    end
    if (wr && !old_bsy)
      case (t)
        3: m_feat = d[7:0];
        4: m_scnt = d[7:0];
        5: m_snum = d[7:0];
        6: m_cyll = d[7:0];
        7: m_cylh = d[7:0];
        8: m_head = d[7:0];
        default: ;
      endcase
    if (wr && t == 10) begin m_srst = d[2]; m_nien = d[1]; end
    if (srstw) begin
      m_feat = 0; m_scnt = 1; m_snum = 1; m_cyll = 0; m_cylh = 0; m_head = 0;
      m_byte = 0; m_tgl = 0;
    end
    if (srstw || old_srst) m_bsy = 1;
    else if (cmdacc) m_bsy = 1;
    else if (done) m_bsy = 0;
    if (srstw) m_irq = 0;
    else if (irq) m_irq = 1;
    else if (rd && t == 9) m_irq = 0;
    if (fifo_pop_o && rq.size() > 0) void'(rq.pop_front());
    fifo_rdata_i = (rq.size() > 0) ? rq[0] : 16'h0;
    @(negedge clk_i);
  endtask

  bit finished = 0;

  initial begin
    #(200000 * 5ns);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cur_req = "R12"; step(0); step(0);

    cur_req = "R1";
    step(2, 2, 16'h0022); step(2, 3, 16'h0033); step(2, 4, 16'h0044);
    step(2, 5, 16'h0055); step(2, 6, 16'h00E6);
    for (int i = 2; i < 8; i++) step(1, 3'(i));
    cur_req = "R7";
    step(2, 1, 16'h0011); step(1, 1); core_err_i = 8'h40; step(1, 1);

    cur_req = "R6";
    rq = {16'h1234, 16'h5678, 16'h9ABC}; fifo_rdata_i = rq[0];
    step(1, 0); step(1, 0); step(2, 0, 16'hBEEF); step(2, 0, 16'hCAFE);
    cur_req = "R4";
    step(1, 1, 0, 1); step(2, 1, 16'h7777, 1); step(0);

    cur_req = "R3";
    rq = {16'h0F0F, 16'hF0F0}; fifo_rdata_i = rq[0];
    step(5, 5); step(6, 3, 16'hA5A5); step(5, 7);

    cur_req = "R9";
    step(2, 7, 16'h0020); step(0); step(0);
    cur_req = "R10";
    step(2, 2, 16'h0099); step(2, 1, 16'h0055); step(2, 7, 16'h0030); step(0);
    cur_req = "R9";
    step(0, 0, 0, 0, 1); step(1, 7);

    cur_req = "R5";
    step(2, 1, 16'h0001); step(2, 7, 16'h00EF); step(0); step(0, 0, 0, 0, 1);
    rq = {16'hA1B2, 16'hC3D4}; fifo_rdata_i = rq[0];
    step(1, 0); step(1, 0); step(1, 0); step(1, 0);
    step(2, 0, 16'h0011); step(2, 0, 16'h0022);
    cur_req = "R3";
    rq = {16'h4321}; fifo_rdata_i = rq[0];
    step(5, 0); step(6, 0, 16'h8765);
    cur_req = "R5";
    step(2, 1, 16'h0081); step(2, 7, 16'h00EF); step(0, 0, 0, 0, 1);
    rq = {16'h2468}; fifo_rdata_i = rq[0];
    step(1, 0);

    cur_req = "R8";
    step(0, 0, 0, 0, 0, 1); step(3, 6); step(0);
    cur_req = "R2";
    step(4, 6, 16'h0002); step(3, 6); step(4, 6, 16'h0000);
    cur_req = "R8";
    step(1, 7); step(0);

    cur_req = "R11";
    step(2, 2, 16'h0042); step(0, 0, 0, 0, 0, 1);
    step(4, 6, 16'h0004); step(0); step(2, 3, 16'h0077);
    step(0, 0, 0, 0, 1); step(4, 6, 16'h0000); step(1, 7);
    step(0, 0, 0, 0, 1); step(1, 7);

    cur_req = "R13";
    rq = {16'h1111}; fifo_rdata_i = rq[0];
    step(7, 0); step(8, 0); step(3, 5); step(0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule